// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Sequencer

This block models the digital control of a successive-approximation converter whose result leaves on a three-wire serial port. It runs on a system clock. It samples an active-low chip-select and a serial clock, and it finds their falling edges itself. A chip-select falling edge starts a frame. The block presents a midscale trial code to an external DAC model and then runs a binary search on a comparator input. The search resolves one bit on every serial clock falling edge. Each resolved bit is shifted out at once, in two's complement, after a single leading null bit.

The data output has its own output-enable. The enable drops after the least significant bit has been sent, and it also drops as soon as chip-select rises. A frame may therefore be cut short after any number of clocks. A power-state flag is high only while chip-select is low. The first frame after reset is a dummy frame: the converter sequences normally, but the output is never driven during it.

The block can be used as a synthesizable stand-in for the converter, or as a reference model beside one.

Top module: `sar_serial_seq`

## Requirements
- R1: One clock after a chip-select falling edge is sampled, trial_code equals midscale (only bit N-1 set, 0x800 for N=12) and dyn_mode is high.
- R2: On each serial clock falling edge during a frame, the bit under test is kept when cmp_hi is high (sample at or above the trial level) and cleared otherwise. The next lower bit is then set as the new trial. After N edges, trial_code equals the sampled value in offset binary.
- R3: Outside the dummy frame, sdo_oe goes high with sdo low (the null bit) one clock after the chip-select falling edge. After serial falling edge k (1..N), sdo carries result bit N-k, most significant first.
- R4: The serial result is in two's complement, formed by inverting the offset-binary MSB. The lowest input gives 0x800, the highest 0x7FF, and midscale 0x000.
- R5: After serial falling edge N+1, sdo_oe is low and stays low through further serial clocks while chip-select stays low.
- R6: One clock after chip-select is sampled high, sdo_oe and dyn_mode are low, whatever the number of serial clocks seen.
- R7: After a frame cut short after k < N serial edges, trial_code holds the k resolved upper bits and zeros in every other bit.
- R8: During the first frame after reset, sdo_oe stays low; frames after it drive the output.
- R9: During and right after reset, sdo_oe, sdo, dyn_mode and trial_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select, sampled on clk |
| sclk | input | 1 | Serial clock, sampled on clk |
| cmp_hi | input | 1 | Comparator: sample at or above trial level |
| trial_code | output | N | Offset-binary trial code to the DAC model |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output-enable for sdo (low means high impedance) |
| dyn_mode | output | 1 | High in dynamic mode, low in static mode |

## Verification
The bench targets the end points of the transfer function. A design that inverts no bit, or the wrong bit, turns 0x800 and 0x7FF around. It also checks the edge right after the LSB. A design that counts one edge too many or too few leaves the output enabled too long or cuts off the LSB. Short frames of zero to eleven clocks show whether the pending trial bit is left set in the code. The dummy first frame and the frame that follows it show whether the dummy flag is cleared too early or never cleared at all.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_DRAIN = 2'd2
  } sss_state_e;
endpackage

// File: rtl/sss_fall_det.sv
module sss_fall_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= RST_VAL;
    else        din_q <= din;
  end

  assign fall = din_q & ~din;
endmodule

// File: rtl/sss_ctrl.sv
module sss_ctrl
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       cs_fall,
  input  logic       sclk_fall,
  input  logic       cnt_done,
  output logic       start,
  output logic       step,
  output logic       abort,
  output logic       drive_en,
  output logic       dyn_mode
);
  sss_state_e state_q, state_n;
  logic       dummy_q, dummy_n;
  logic       dyn_q, dyn_n;

  assign start    = ~cs_n & cs_fall;
  assign step     = ~cs_n & ~cs_fall & sclk_fall & (state_q == ST_CONV);
  assign abort    = cs_n & (state_q == ST_CONV);
  assign drive_en = ~dummy_q;
  assign dyn_mode = dyn_q;

  always_comb begin
    state_n = state_q;
    dummy_n = dummy_q;
    dyn_n   = ~cs_n;
    if (cs_n) begin
      state_n = ST_IDLE;
    end else if (cs_fall) begin
      state_n = ST_CONV;
      dummy_n = 1'b0;
    end else if (step && cnt_done) begin
      state_n = ST_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dummy_q <= 1'b1;
      dyn_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      dummy_q <= dummy_n;
      dyn_q   <= dyn_n;
    end
  end
endmodule

// File: rtl/sss_sar.sv
module sss_sar #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic         abort,
  input  logic         cmp_hi,
  output logic [N-1:0] code,
  output logic         cnt_done,
  output logic         bit_out
);
  localparam int CW = $clog2(N + 1);
  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0]  code_q, code_n;
  logic [CW-1:0] cnt_q, cnt_n;
  int            idx;

  assign idx      = N - 1 - int'(cnt_q);
  assign cnt_done = (cnt_q == CW'(N));
  assign bit_out  = (cnt_q == '0) ? ~cmp_hi : cmp_hi;
  assign code     = code_q;

  always_comb begin
    code_n = code_q;
    cnt_n  = cnt_q;
    if (start) begin
      code_n = MID;
      cnt_n  = '0;
    end else if (step && !cnt_done) begin
      for (int i = 0; i < N; i++) begin
        if (i == idx)          code_n[i] = cmp_hi;
        else if (i + 1 == idx) code_n[i] = 1'b1;
      end
      cnt_n = cnt_q + 1'b1;
    end else if (abort && !cnt_done) begin
      for (int i = 0; i < N; i++) begin
        if (i == idx) code_n[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/sss_txout.sv
module sss_txout (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic start,
  input  logic step,
  input  logic cnt_done,
  input  logic drive_en,
  input  logic bit_in,
  output logic sdo,
  output logic sdo_oe
);
  logic sdo_q, sdo_n, oe_q, oe_n;

  always_comb begin
    sdo_n = sdo_q;
    oe_n  = oe_q;
    if (cs_n) begin
      sdo_n = 1'b0;
      oe_n  = 1'b0;
    end else if (start) begin
      sdo_n = 1'b0;
      oe_n  = drive_en;
    end else if (step) begin
      if (cnt_done) begin
        sdo_n = 1'b0;
        oe_n  = 1'b0;
      end else begin
        sdo_n = bit_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sdo_q <= sdo_n;
      oe_q  <= oe_n;
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         cmp_hi,
  output logic [N-1:0] trial_code,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         dyn_mode
);
  logic cs_fall, sclk_fall;
  logic start, step, abort, drive_en, cnt_done, bit_res;

  sss_fall_det #(.RST_VAL(1'b1)) u_cs_det (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .fall(cs_fall)
  );

  sss_fall_det #(.RST_VAL(1'b0)) u_sclk_det (
    .clk(clk), .rst_n(rst_n), .din(sclk), .fall(sclk_fall)
  );

  sss_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .cnt_done(cnt_done), .start(start),
    .step(step), .abort(abort), .drive_en(drive_en), .dyn_mode(dyn_mode)
  );

  sss_sar #(.N(N)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .abort(abort),
    .cmp_hi(cmp_hi), .code(trial_code), .cnt_done(cnt_done), .bit_out(bit_res)
  );

  sss_txout u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .step(step),
    .cnt_done(cnt_done), .drive_en(drive_en), .bit_in(bit_res),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic [N-1:0] trial_code,
  input logic         sdo,
  input logic         sdo_oe,
  input logic         dyn_mode
);
  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  a_r6_cs_high_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  a_r6_static_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_mode |-> !sdo_oe);

  a_r3_null_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  a_r1_midscale_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |=> (trial_code == MID) && dyn_mode);

  a_r5_no_reenable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !cs_n && !$past(cs_n)) |=> !sdo_oe);
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .trial_code(trial_code),
  .sdo(sdo), .sdo_oe(sdo_oe), .dyn_mode(dyn_mode)
);

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam logic [N-1:0] MID = 12'h800;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, cmp_hi;
  logic [N-1:0] vin, trial_code;
  logic sdo, sdo_oe, dyn_mode;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_hi = (vin >= trial_code);

  sar_serial_seq #(.N(N)) u_sar_serial_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .cmp_hi(cmp_hi),
    .trial_code(trial_code), .sdo(sdo), .sdo_oe(sdo_oe), .dyn_mode(dyn_mode)
  );

  function automatic logic [N-1:0] twos(input logic [N-1:0] v);
    return v ^ MID;
  endfunction

  function automatic logic [N-1:0] kept(input logic [N-1:0] v, input int k);
    logic [31:0] m;
    if (k >= N) return v;
    m = (32'd1 << (N - k)) - 32'd1;
    return v & ~m[N-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [N-1:0] v, input int nfall, input bit dummy);
    logic [N-1:0] word = '0;
    vin = v;
    cs_n = 1'b0;
    tick(2);
    chk(trial_code == MID, "R1", trial_code, MID);
    chk(dyn_mode == 1'b1, "R1", dyn_mode, 1);
    chk(sdo_oe == !dummy, dummy ? "R8" : "R3", sdo_oe, !dummy);
    chk(sdo == 1'b0, "R3", sdo, 0);
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b1; tick(2);
      sclk = 1'b0; tick(2);
      if (k <= N) begin
        word = {word[N-2:0], sdo};
        if (dummy) chk(sdo_oe == 1'b0, "R8", sdo_oe, 0);
        else begin
          chk(sdo_oe == 1'b1, "R3", sdo_oe, 1);
          chk(sdo == twos(v)[N-k], "R3", sdo, twos(v)[N-k]);
        end
        if (k == N) begin
          chk(trial_code == v, "R2", trial_code, v);
          if (!dummy) chk(word == twos(v), "R4", word, twos(v));
        end
      end else begin
        chk(sdo_oe == 1'b0, "R5", sdo_oe, 0);
      end
    end
    cs_n = 1'b1;
    tick(2);
    chk(sdo_oe == 1'b0, "R6", sdo_oe, 0);
    chk(dyn_mode == 1'b0, "R6", dyn_mode, 0);
    chk(trial_code == kept(v, nfall), "R7", trial_code, kept(v, nfall));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; vin = '0;
    tick(3);
    // R9 reset values
    chk(sdo_oe == 0 && sdo == 0 && dyn_mode == 0 && trial_code == 0, "R9",
        {sdo_oe, sdo, dyn_mode}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(sdo_oe == 0 && trial_code == 0, "R9", trial_code, 0);
    // R8 dummy frame, then a driven frame
    frame(12'h5A3, N + 1, 1'b1);
    frame(12'h5A3, N + 1, 1'b0);
    // R4 transfer end points
    frame(12'h000, N, 1'b0);
    frame(12'hFFF, N, 1'b0);
    frame(12'h800, N, 1'b0);
    // R5 held low after LSB with extra clocks
    frame(12'h3C7, N + 4, 1'b0);
    // R7 short cycles, including zero clocks
    frame(12'hABC, 0, 1'b0);
    frame(12'hABC, 5, 1'b0);
    frame(12'h7FF, N - 1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] v = N'($urandom);
      int nf = (i % 3 == 0) ? int'($urandom % (N + 3)) : N + 1;
      frame(v, nf, 1'b0);
    end
    finish_run();
  end
endmodule